// File: doc/BRIEF.md
# Nibble-Wide Display Bus Master

This block connects a host to a character display controller through a 4-bit parallel bus. The host hands over one byte at a time on a valid/ready request channel. Each request carries a register-or-data select, a read flag and, for writes, the byte itself. The master moves the byte as two nibbles, high nibble first. Each nibble gets its own enable pulse on a bus that also carries a register select line and a read/write line. On a read the master assembles the two returned nibbles into a byte and presents it with a one-cycle valid strobe.

A separate init pulse makes the master reset the display controller. The active-low reset line is asserted only in cycles where the target reports a running clock. Only those cycles count toward the programmed reset length. When no transfer or reset is in progress, the bus sits in standby: data lines driven to all ones, register select and read/write high, and enable low. This matches the pull-up resistors on the target.

Requests see back-pressure through `req_ready`, which is high only in standby with no init pulse present. A request that is held while `req_ready` is low stays pending until it is taken. The response channel carries no back-pressure: the host must take `rsp_data` in the cycle `rsp_valid` is high. All timing is counted in system clocks.

Top module: `nib_disp_master`

## Requirements
- R1: In standby (busy low), outputs are `disp_db_out`=4'hF with `disp_db_oe`=1, `disp_rs`=1, `disp_rw`=1, `disp_en`=0 and `disp_rst_n`=1. This is also the state after reset.
- R2: A write sends `req_wdata[7:4]` on the first enable pulse and `req_wdata[3:0]` on the second, with `disp_rw`=0 and `disp_db_oe`=1.
- R3: `disp_rs` equals the request's `req_rs` for both nibbles. `disp_rw` is 1 for reads, and `disp_db_oe` is 0 whenever enable is high on a read.
- R4: On a read, `disp_db_in` is sampled in the last enable-high cycle of each nibble. One cycle after the second nibble's hold ends, `rsp_valid` pulses for one cycle with the first nibble in `rsp_data[7:4]` and the second in `rsp_data[3:0]`.
- R5: `disp_rs` and `disp_rw` are unchanged for at least SETUP_CLKS cycles before each enable rise. They stay unchanged for at least HOLD_CLKS cycles after each enable fall.
- R6: Each enable pulse is high for exactly EN_CLKS cycles.
- R7: `busy` rises in the cycle after a request is accepted. It stays high for exactly 2*(SETUP_CLKS+EN_CLKS+HOLD_CLKS) cycles and then returns to standby.
- R8: After `init_start`, `disp_rst_n` is low only in cycles where `tgt_clk_ok` is 1, for RST_CLKS such cycles in total, and then the block returns to standby.
- R9: `req_ready` is 0 while busy, and a request held during that time is not taken.
- R10: When `init_start` and `req_valid` are both high in standby, the reset sequence is started and the request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_start | input | 1 | Pulse that starts a target reset sequence |
| tgt_clk_ok | input | 1 | Target's clock is running |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_rs | input | 1 | 1 = data access, 0 = register access |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte valid (single cycle) |
| rsp_data | output | 8 | Assembled read byte |
| busy | output | 1 | Transfer or reset in progress |
| disp_db_out | output | 4 | Data lines driven value |
| disp_db_oe | output | 1 | Data line output enable |
| disp_db_in | input | 4 | Data lines as seen from the target |
| disp_rs | output | 1 | Register select |
| disp_rw | output | 1 | Read/write, 1 = read |
| disp_en | output | 1 | Bus enable strobe |
| disp_rst_n | output | 1 | Active-low target reset |

## Verification
The bench builds the block with SETUP_CLKS=2, EN_CLKS=3, HOLD_CLKS=1 and RST_CLKS=20. With these short values, dozens of full byte transfers and several reset sequences fit in a brief run. The setup margins and enable widths stay unequal, so an off-by-one in any single phase counter shows up on its own. The short reset length lets the bench toggle the target clock flag many times within one reset. This checks that only clocked cycles count and that reset never goes low without the clock.

// File: rtl/nd_pkg.sv
package nd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RST   = 3'd1,
    ST_SETUP = 3'd2,
    ST_EN    = 3'd3,
    ST_HOLD  = 3'd4
  } nd_state_e;

  function automatic int nd_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nd_phase_timer.sv
module nd_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nd_rd_gather.sv
module nd_rd_gather #(
  parameter int NW    = 4,
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap,
  input  logic                sel_lo,
  input  logic [NW-1:0]       nib_in,
  output logic [NW*LANES-1:0] byte_out
);
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NW-1:0] lane_q;
    // lane 0 holds the first (most significant) nibble
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lane_q <= '0;
      else if (cap && (SW'(sel_lo) == SW'(g)))     lane_q <= nib_in;
    end
    assign byte_out[NW*(LANES-g)-1 -: NW] = lane_q;
  end
endmodule

// File: rtl/nib_disp_master.sv
module nib_disp_master
  import nd_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int EN_CLKS    = 4,
  parameter int HOLD_CLKS  = 2,
  parameter int RST_CLKS   = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_start,
  input  logic       tgt_clk_ok,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_rd,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       busy,
  output logic [3:0] disp_db_out,
  output logic       disp_db_oe,
  input  logic [3:0] disp_db_in,
  output logic       disp_rs,
  output logic       disp_rw,
  output logic       disp_en,
  output logic       disp_rst_n
);
  localparam int NW     = 4;
  localparam int MAXLEN = nd_max(nd_max(SETUP_CLKS, EN_CLKS), nd_max(HOLD_CLKS, RST_CLKS));
  localparam int CW     = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] LD_EN    = CW'(EN_CLKS - 1);
  localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CLKS - 1);
  localparam logic [CW-1:0] LD_RST   = CW'(RST_CLKS - 1);

  nd_state_e state, state_nx;
  logic          t_load, t_tick, t_zero;
  logic [CW-1:0] t_val;
  logic          op_rs, op_rd, nib_lo;
  logic [7:0]    op_data;
  logic          accept, xfer, cap, last_hold;

  assign accept    = req_valid && req_ready;
  assign xfer      = (state == ST_SETUP) || (state == ST_EN) || (state == ST_HOLD);
  assign last_hold = (state == ST_HOLD) && t_zero && nib_lo;
  assign cap       = (state == ST_EN) && t_zero && op_rd;

  always_comb begin
    state_nx = state;
    t_load   = 1'b0;
    t_val    = LD_SETUP;
    unique case (state)
      ST_IDLE: begin
        if (init_start) begin
          state_nx = ST_RST;  t_load = 1'b1; t_val = LD_RST;
        end else if (req_valid) begin
          state_nx = ST_SETUP; t_load = 1'b1; t_val = LD_SETUP;
        end
      end
      ST_RST:   if (tgt_clk_ok && t_zero) state_nx = ST_IDLE;
      ST_SETUP: if (t_zero) begin state_nx = ST_EN;   t_load = 1'b1; t_val = LD_EN;   end
      ST_EN:    if (t_zero) begin state_nx = ST_HOLD; t_load = 1'b1; t_val = LD_HOLD; end
      ST_HOLD: if (t_zero) begin
        if (nib_lo) state_nx = ST_IDLE;
        else begin state_nx = ST_SETUP; t_load = 1'b1; t_val = LD_SETUP; end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  assign t_tick = (state == ST_RST) ? tgt_clk_ok : 1'b1;

  nd_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .tick(t_tick), .zero(t_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_rs     <= 1'b1;
      op_rd     <= 1'b0;
      op_data   <= '0;
      nib_lo    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state     <= state_nx;
      rsp_valid <= last_hold && op_rd;
      if (accept) begin
        op_rs   <= req_rs;
        op_rd   <= req_rd;
        op_data <= req_wdata;
        nib_lo  <= 1'b0;
      end else if ((state == ST_HOLD) && t_zero) begin
        nib_lo  <= 1'b1;
      end
    end
  end

  nd_rd_gather #(.NW(NW), .LANES(2)) u_gather (
    .clk(clk), .rst_n(rst_n), .cap(cap), .sel_lo(nib_lo),
    .nib_in(disp_db_in), .byte_out(rsp_data)
  );

  assign req_ready   = (state == ST_IDLE) && !init_start;
  assign busy        = (state != ST_IDLE);
  assign disp_rs     = xfer ? op_rs : 1'b1;
  assign disp_rw     = xfer ? op_rd : 1'b1;
  assign disp_db_oe  = !(xfer && op_rd);
  assign disp_db_out = (xfer && !op_rd) ? (nib_lo ? op_data[3:0] : op_data[7:4]) : 4'hF;
  assign disp_en     = (state == ST_EN);
  assign disp_rst_n  = !((state == ST_RST) && tgt_clk_ok);
endmodule

// File: rtl/nd_chk.sv
module nd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tgt_clk_ok,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       busy,
  input logic [3:0] disp_db_out,
  input logic       disp_db_oe,
  input logic       disp_rs,
  input logic       disp_rw,
  input logic       disp_en,
  input logic       disp_rst_n
);
  // R1
  standby_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (disp_db_out == 4'hF && disp_db_oe && disp_rs && disp_rw && !disp_en && disp_rst_n));
  // R8
  rst_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_rst_n |-> tgt_clk_ok);
  // R9
  no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R4
  rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && $past(busy)));
  // R3
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && disp_rw) |-> !disp_db_oe);
  // R5
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_en) |-> ($stable(disp_rs) && $stable(disp_rw)));
  // R5
  ctl_during_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && $past(disp_en)) |-> ($stable(disp_rs) && $stable(disp_rw)));
endmodule

bind nib_disp_master nd_chk u_chk (.*);

// File: tb/sim_nib_disp_master.sv
module sim_nib_disp_master;
  localparam int S = 2, E = 3, H = 1, R = 20;

  logic clk = 0, rst_n = 0;
  logic init_start = 0, tgt_clk_ok = 1;
  logic req_valid = 0, req_rs = 0, req_rd = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, busy, disp_db_oe, disp_rs, disp_rw, disp_en, disp_rst_n;
  logic [7:0] rsp_data;
  logic [3:0] disp_db_out, disp_db_in;

  int checks = 0, failures = 0;
  logic [7:0] tgt_byte = 8'h00;
  logic rd_lo = 0;

  always #4 clk = ~clk;

  nib_disp_master #(.SETUP_CLKS(S), .EN_CLKS(E), .HOLD_CLKS(H), .RST_CLKS(R)) u0 (.*);

  assign disp_db_in = rd_lo ? tgt_byte[3:0] : tgt_byte[7:4];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // bus monitor
  logic prev_en = 0, prev_rs = 1, prev_rw = 1, fell_seen = 0;
  int stable_cnt = 0, ehigh = 0, since_fall = 0;
  int nib_cnt = 0, rst_low = 0, busy_cnt = 0, rsp_cnt = 0, en_rises = 0;
  logic [3:0] nibs [2];
  logic nrs [2], nrw [2], noe [2];
  logic [7:0] rsp_last;

  always @(negedge clk) if (rst_n) begin
    if (disp_en && !prev_en) begin
      en_rises++;
      chk(stable_cnt >= S, "R5 setup", stable_cnt, S);
      if (nib_cnt < 2) begin
        nibs[nib_cnt] = disp_db_out; nrs[nib_cnt] = disp_rs;
        nrw[nib_cnt] = disp_rw; noe[nib_cnt] = disp_db_oe;
      end
      nib_cnt++;
      ehigh = 1;
      fell_seen = 0;
    end else if (disp_en) ehigh++;
    if (!disp_en && prev_en) begin
      chk(ehigh == E, "R6 enable width", ehigh, E);
      rd_lo = ~rd_lo;
      fell_seen = 1; since_fall = 0;
    end
    if ((disp_rs != prev_rs || disp_rw != prev_rw) && fell_seen) begin
      chk(since_fall >= H, "R5 hold", since_fall, H);
      fell_seen = 0;
    end
    if (disp_rs == prev_rs && disp_rw == prev_rw) stable_cnt++; else stable_cnt = 1;
    if (!disp_en) since_fall++;
    if (!disp_rst_n) rst_low++;
    if (busy) busy_cnt++; else rd_lo = 0;
    if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_data; end
    prev_en = disp_en; prev_rs = disp_rs; prev_rw = disp_rw;
  end

  task automatic xact(input logic rs, input logic rd, input logic [7:0] d);
    @(negedge clk);
    nib_cnt = 0; busy_cnt = 0; rsp_cnt = 0;
    if (rd) tgt_byte = d;
    req_valid = 1; req_rs = rs; req_rd = rd; req_wdata = rd ? ~d : d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R9: held request sees no ready while busy
    chk(busy && !req_ready, "R9 ready low while busy", req_ready, 0);
    req_wdata = $urandom;
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(nib_cnt == 2, "R9 one byte per request", nib_cnt, 2);
    chk(busy_cnt == 2*(S+E+H), "R7 busy length", busy_cnt, 2*(S+E+H));
    chk(nrs[0] == rs && nrs[1] == rs, "R3 register select", {nrs[0], nrs[1]}, {rs, rs});
    if (rd) begin
      chk(nrw[0] && nrw[1] && !noe[0] && !noe[1], "R3 read direction", {nrw[0], noe[0]}, 2'b10);
      chk(rsp_cnt == 1 && rsp_last == d, "R4 read byte", rsp_last, d);
    end else begin
      chk(!nrw[0] && noe[0], "R2 write direction", {nrw[0], noe[0]}, 2'b01);
      chk({nibs[0], nibs[1]} == d, "R2 nibble order", {nibs[0], nibs[1]}, d);
      chk(rsp_cnt == 0, "R4 no response on write", rsp_cnt, 0);
    end
    chk(disp_db_out == 4'hF && disp_db_oe && disp_rs && disp_rw, "R1 standby after transfer",
        {disp_db_out, disp_db_oe, disp_rs, disp_rw}, 7'h7F);
  endtask

  task automatic do_init(input bit with_req, input bit jitter);
    int rises0;
    @(negedge clk);
    rst_low = 0; rises0 = en_rises;
    init_start = 1; req_valid = with_req; req_rs = 1; req_rd = 0; req_wdata = 8'h5A;
    @(negedge clk);
    init_start = 0; req_valid = 0;
    chk(busy, "R10 init wins", busy, 1);
    while (busy) begin
      if (jitter) tgt_clk_ok = $urandom_range(0, 1);
      @(negedge clk);
    end
    tgt_clk_ok = 1;
    @(negedge clk);
    chk(rst_low == R, "R8 reset low count", rst_low, R);
    chk(en_rises == rises0, "R10 request not taken", en_rises - rises0, 0);
    chk(disp_rst_n && !busy, "R8 back to standby", {disp_rst_n, busy}, 2'b10);
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    chk(!busy && req_ready && !disp_en && disp_rst_n && disp_db_out == 4'hF && disp_db_oe
        && disp_rs && disp_rw, "R1 reset state", {busy, disp_en, disp_db_out}, 6'h0F);
    rst_n = 1;
    repeat (2) @(negedge clk);
    xact(1'b0, 1'b0, 8'hA5);
    xact(1'b1, 1'b0, 8'h00);
    xact(1'b1, 1'b0, 8'hFF);
    xact(1'b1, 1'b1, 8'h3C);
    xact(1'b0, 1'b1, 8'hC3);
    do_init(1'b0, 1'b0);
    do_init(1'b1, 1'b1);
    do_init(1'b0, 1'b1);
    for (int i = 0; i < 24; i++)
      xact(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule